// File: doc/BRIEF.md
# Programmable 16x Baud Clock Divider

This block turns a free-running reference clock into the 16x sampling clock used by an asynchronous serial transmitter and receiver. A CPU loads a 16-bit divisor N one byte at a time into two latches. From then on the block repeats a period of N reference cycles. Each period produces a shaped output clock for the serial logic, and a one-cycle enable strobe for logic that runs on the reference clock. The transmitter takes the output clock directly. The receiver takes it too when that output is wired back to its clock input.

A small state machine drives the output. Its states are: `DIV_STOP` for a divisor of zero, where the output is idle; `DIV_PASS` for a divisor of one, where the output clock is the reference clock itself; `DIV_MARK` for the high part of a period; and `DIV_SPACE` for the low part. Its transitions are:
- Stop or pass to mark, when a divisor of two or more is present.
- Mark to space, when the high part of the period has run its length.
- Space to mark, when the phase counter wraps at N-1.
- Any state to mark at phase zero, on a write to either latch (restart).
- Any state to stop or pass, when the divisor becomes 0 or 1.

The high part lasts one cycle for divisors 2 and 3, and two cycles for larger divisors.

Top module: `baud16_divider`

## Requirements
- R1: After reset both divisor bytes are zero, so the block is stopped: `tick` is 0 and `baud_clk` is 0.
- R2: A write with `wr_sel`=0 loads divisor bits 7:0 from `wr_data`, and a write with `wr_sel`=1 loads bits 15:8. The other byte keeps its value, and neither byte changes without a write.
- R3: With divisor 0, `baud_clk` stays low and `tick` never asserts.
- R4: With divisor 1, `baud_clk` equals the reference clock and `tick` is high in every cycle.
- R5: With divisor 2, `baud_clk` alternates one cycle high and one cycle low.
- R6: With divisor 3, each period is one cycle high followed by two cycles low.
- R7: With a divisor N of 4 or more (up to 65535), each period is N cycles: two cycles high followed by N-2 cycles low.
- R8: For divisors of 2 or more, `tick` is high for exactly the first cycle of each period, which is also a cycle where `baud_clk` is high.
- R9: A write to either byte restarts the sequence. The cycle that follows the write edge is the first cycle of a period of the new divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Master reset, active high, synchronous |
| wr_en | input | 1 | Divisor byte write strobe |
| wr_sel | input | 1 | Byte select: 0 = bits 7:0, 1 = bits 15:8 |
| wr_data | input | 8 | Byte to load |
| tick | output | 1 | One-cycle enable at each period start |
| baud_clk | output | 1 | Shaped 16x baud clock |

## Verification
The assertions assume that `wr_sel` only ever names one of the two existing byte lanes. They also assume that writes, when checking the shape of a period, do not land in the cycle right after a period start; the pulse-width properties are conditioned on `wr_en` being low there. The stimulus respects both assumptions. Writes come only from a byte-write task with a one-bit select, and each divisor is observed for several full periods with no write in that window. The one exception is a directed mid-period rewrite, which checks the restart rule on its own. Random divisors are drawn mostly from 0 to 40, so the special shapes come up often. Directed cases cover the full 16-bit range, writes to a single byte, and reset during operation.

// File: rtl/baud_pkg.sv
package baud_pkg;

    // Sequencer states of the divider
    typedef enum logic [1:0] {
        DIV_STOP  = 2'd0,
        DIV_PASS  = 2'd1,
        DIV_MARK  = 2'd2,
        DIV_SPACE = 2'd3
    } div_state_e;

    // High-part length of a period for divisors above three
    localparam int MARK_CYC = 2;

    // Divisors that use a one-cycle high part
    localparam int SHORT_LO = 2;
    localparam int SHORT_HI = 3;

endpackage

// File: rtl/baud_latch.sv
module baud_latch #(
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_q,
    output logic [DIV_W-1:0]  div_next,
    output logic              load
);

    localparam int NLANES = DIV_W / BYTE_W;

    logic [BYTE_W-1:0] lane_q  [NLANES];
    logic [BYTE_W-1:0] lane_nx [NLANES];

    generate
        for (genvar i = 0; i < NLANES; i++) begin : g_lane
            logic hit;

            assign hit = wr_en && (wr_sel == SEL_W'(i));

            always_ff @(posedge clk) begin
                if (rst) begin
                    lane_q[i] <= '0;
                end else if (hit) begin
                    lane_q[i] <= wr_data;
                end
            end

            always_comb begin
                lane_nx[i] = hit ? wr_data : lane_q[i];
            end

            assign div_q[i*BYTE_W +: BYTE_W]    = lane_q[i];
            assign div_next[i*BYTE_W +: BYTE_W] = lane_nx[i];
        end
    endgenerate

    // Any latch write restarts the period
    assign load = wr_en;

endmodule

// File: rtl/baud_seq.sv
module baud_seq
    import baud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] div_next,
    output div_state_e       state_n,
    output logic [DIV_W-1:0] phase_n
);

    div_state_e       state_q;
    logic [DIV_W-1:0] phase_q;
    logic             restart;
    logic             wrap;
    logic [DIV_W-1:0] mark_len;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_STOP;
            phase_q <= '0;
        end else begin
            state_q <= state_n;
            phase_q <= phase_n;
        end
    end

    // Next-state and phase logic
    always_comb begin
        unique case (state_q)
            DIV_STOP,
            DIV_PASS:  restart = 1'b1;
            DIV_MARK,
            DIV_SPACE: restart = load;
            default:   restart = 1'b1;
        endcase

        if (div_next == DIV_W'(SHORT_LO) || div_next == DIV_W'(SHORT_HI)) begin
            mark_len = DIV_W'(1);
        end else begin
            mark_len = DIV_W'(MARK_CYC);
        end

        wrap    = (phase_q >= (div_next - DIV_W'(1)));
        state_n = DIV_STOP;
        phase_n = '0;

        if (div_next == '0) begin
            state_n = DIV_STOP;
        end else if (div_next == DIV_W'(1)) begin
            state_n = DIV_PASS;
        end else begin
            phase_n = (restart || wrap) ? '0 : (phase_q + DIV_W'(1));
            state_n = (phase_n < mark_len) ? DIV_MARK : DIV_SPACE;
        end
    end

endmodule

// File: rtl/baud_shape.sv
module baud_shape
    import baud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  div_state_e       state_n,
    input  logic [DIV_W-1:0] phase_n,
    output logic             tick,
    output logic             mark,
    output logic             baud_clk
);

    logic tick_r;
    logic mark_r;
    logic pass_r;

    // Output registers, loaded from the next state so they line up with it
    always_ff @(posedge clk) begin
        if (rst) begin
            tick_r <= 1'b0;
            mark_r <= 1'b0;
            pass_r <= 1'b0;
        end else begin
            unique case (state_n)
                DIV_STOP: begin
                    tick_r <= 1'b0;
                    mark_r <= 1'b0;
                    pass_r <= 1'b0;
                end
                DIV_PASS: begin
                    tick_r <= 1'b1;
                    mark_r <= 1'b0;
                    pass_r <= 1'b1;
                end
                DIV_MARK: begin
                    tick_r <= (phase_n == '0);
                    mark_r <= 1'b1;
                    pass_r <= 1'b0;
                end
                DIV_SPACE: begin
                    tick_r <= 1'b0;
                    mark_r <= 1'b0;
                    pass_r <= 1'b0;
                end
                default: begin
                    tick_r <= 1'b0;
                    mark_r <= 1'b0;
                    pass_r <= 1'b0;
                end
            endcase
        end
    end

    assign tick     = tick_r;
    assign mark     = mark_r;
    assign baud_clk = pass_r ? clk : mark_r;

endmodule

// File: rtl/baud16_divider.sv
module baud16_divider
    import baud_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = (DIV_W / BYTE_W > 1) ? $clog2(DIV_W / BYTE_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              tick,
    output logic              baud_clk
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_next;
    logic             load;
    div_state_e       state_n;
    logic [DIV_W-1:0] phase_n;
    logic             mark_w;

    baud_latch #(
        .DIV_W (DIV_W),
        .BYTE_W(BYTE_W),
        .SEL_W (SEL_W)
    ) u_latch (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .div_q   (div_q),
        .div_next(div_next),
        .load    (load)
    );

    baud_seq #(
        .DIV_W(DIV_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .div_next(div_next),
        .state_n (state_n),
        .phase_n (phase_n)
    );

    baud_shape #(
        .DIV_W(DIV_W)
    ) u_shape (
        .clk     (clk),
        .rst     (rst),
        .state_n (state_n),
        .phase_n (phase_n),
        .tick    (tick),
        .mark    (mark_w),
        .baud_clk(baud_clk)
    );

endmodule

// File: rtl/baud16_divider_chk.sv
module baud16_divider_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             tick,
    input logic             mark,
    input logic [DIV_W-1:0] div_q
);

    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(div_q));

    // R3
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (div_q == '0) |-> (!tick && !mark));

    // R4
    pass_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (div_q == DIV_W'(1)) |-> tick);

    // R5
    div2_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div_q == DIV_W'(2) && !wr_en) |=> (!mark && !tick));

    // R6
    div3_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div_q == DIV_W'(3) && !wr_en) |=> (!mark && !tick));

    // R7
    wide_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div_q > DIV_W'(3) && !wr_en) |=> (mark && !tick));

    // R8
    tick_in_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div_q > DIV_W'(1)) |-> mark);

    // R9
    reload_start_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (tick || div_q == '0));

endmodule

bind baud16_divider baud16_divider_chk #(
    .DIV_W(DIV_W)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .wr_en(wr_en),
    .tick (tick),
    .mark (mark_w),
    .div_q(div_q)
);

// File: tb/baud16_divider_test.sv
module baud16_divider_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [0:0] wr_sel;
    logic [7:0] wr_data;
    logic       tick;
    logic       baud_clk;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    baud16_divider uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .tick    (tick),
        .baud_clk(baud_clk)
    );

    function automatic bit exp_tick(int n, int k);
        if (n == 0) return 1'b0;
        if (n == 1) return 1'b1;
        return (k % n) == 0;
    endfunction

    // Value expected while the reference clock is low
    function automatic bit exp_low_phase(int n, int k);
        int hl;
        if (n <= 1) return 1'b0;
        hl = (n == 2 || n == 3) ? 1 : 2;
        return (k % n) < hl;
    endfunction

    function automatic string shape_req(int n);
        if (n == 0) return "R3";
        if (n == 1) return "R4";
        if (n == 2) return "R5";
        if (n == 3) return "R6";
        return "R7";
    endfunction

    task automatic check(bit act, bit exp, string req, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic write_byte(bit sel, logic [7:0] val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = val;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    // Observe from the cycle that follows the last write edge
    task automatic observe(int n, int cycles, string first_req);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (k == 0) begin
                check(tick, exp_tick(n, k), first_req, "tick at restart");
            end
            check(tick, exp_tick(n, k), (n > 1) ? "R8" : shape_req(n), "tick");
            check(baud_clk, exp_low_phase(n, k), shape_req(n), "baud_clk");
        end
    endtask

    task automatic set_div(int n);
        write_byte(1'b0, 8'(n));
        write_byte(1'b1, 8'(n >> 8));
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: requirement none, actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        rst     = 1'b1;
        wr_en   = 1'b0;
        wr_sel  = 1'b0;
        wr_data = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state is stopped
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(tick, 1'b0, "R1", "tick after reset");
            check(baud_clk, 1'b0, "R1", "baud_clk after reset");
        end

        // Directed shapes
        set_div(0);   observe(0, 20, "R3");
        set_div(1);   observe(1, 8, "R9");
        @(posedge clk); #2;
        check(baud_clk, 1'b1, "R4", "baud_clk in high clock phase");
        set_div(2);   observe(2, 12, "R9");
        set_div(3);   observe(3, 15, "R9");
        set_div(4);   observe(4, 16, "R9");
        set_div(10);  observe(10, 40, "R9");
        set_div(291); observe(291, 600, "R9");

        // R2: write only the upper byte; the lower byte 0x05 stays
        set_div(5);   observe(5, 10, "R9");
        write_byte(1'b1, 8'h01);
        observe(261, 530, "R2");

        // R2: write only the lower byte; the upper byte 0x01 stays
        write_byte(1'b0, 8'h02);
        observe(258, 300, "R2");

        // R9: rewrite in the middle of a period
        set_div(9);   observe(9, 13, "R9");
        write_byte(1'b1, 8'h00);
        observe(9, 20, "R9");
        write_byte(1'b0, 8'h07);
        observe(7, 21, "R9");

        // R7: largest divisor, first part of one period
        set_div(65535); observe(65535, 2000, "R9");

        // Random divisors
        for (int t = 0; t < 30; t++) begin
            n = $urandom_range(0, 40);
            set_div(n);
            observe(n, 3 * n + 5, "R9");
        end

        // R1: reset during operation clears both bytes
        set_div(6); observe(6, 8, "R9");
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check(tick, 1'b0, "R1", "tick after mid-run reset");
            check(baud_clk, 1'b0, "R1", "baud_clk after mid-run reset");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule